// File: doc/BRIEF.md
# Three-Channel Watchdog Timer with Bark Interrupt

This peripheral holds three independent watchdog channels behind a small word-addressed register bus. Each channel has a counter that advances on a shared reference tick, a bite threshold and a control word. Once the counter has reached the bite threshold while the reset enable is set, the channel raises a reset request. Software services a channel by writing 0 to its counter. Channel 0 also has a bark threshold. The bark threshold sets a latched status bit and drives an interrupt line ahead of the bite.

Channel 0 feeds a dedicated recovery-reset output. Channels 1 and 2 are ORed onto the system-reset output. Each channel runs a three-state reset machine: `CH_OFF` (reset disabled), `CH_ARMED` (enabled, below threshold) and `CH_BITE` (request asserted). The transitions are:
- arm: OFF to ARMED
- fire-on-arm: OFF to BITE
- reach: ARMED to BITE
- service: BITE to ARMED
- disable: ARMED or BITE to OFF

Channel 0 adds a two-state bark machine, `BK_QUIET` and `BK_LATCHED`. Its transitions are:
- latch: QUIET to LATCHED, when the interrupt is enabled and the counter is at or above bark
- acknowledge: LATCHED to QUIET, on a write-one-to-clear while the bark condition is false

Top module: `tri_wdog`

## Requirements
- R1: After reset, every register reads 0 and the recovery-reset, system-reset and interrupt outputs are low.
- R2: Each counter adds 1, modulo 2^DATA_W, on every cycle with `ref_tick` high, and holds its value otherwise.
- R3: A bus write to a counter loads the written value and takes priority over a tick in the same cycle.
- R4: The address is split as `bus_addr[ADDR_W-1:4]` for the channel and `bus_addr[3:2]` for the field: 0 is the counter, 1 the bite threshold, 2 the bark threshold (channel 0 only) and 3 the control word. An address that is not word-aligned, names a channel above 2, or names a bark field on channels 1 or 2 reads 0 and ignores writes.
- R5: In the control word, bit 2 is the reset enable and bit 1 is the bark status. Bit 0 is the interrupt enable. On channels 1 and 2, bits 0 and 1 read 0. All other bits read 0.
- R6: A channel's reset request is high in the cycle after one in which its reset enable is 1 and its counter is greater than or equal to its bite threshold, and low otherwise. A counter and bite threshold both at 0 with the reset enable set therefore fire at once.
- R7: The request of channel 0 drives `recovery_rst_req`. The OR of the requests of channels 1 and 2 drives `system_rst_req`.
- R8: The bark status becomes 1 in the cycle after one in which the interrupt enable is 1 and the counter of channel 0 is at or above the bark threshold.
- R9: Writing a control word with bit 1 set clears the bark status, unless the bark condition holds in that same cycle, in which case the status stays 1.
- R10: `bark_irq` equals the bark status AND the interrupt enable. A latched status with the enable cleared reads back 1 but leaves the line low.
- R11: Clearing a channel's reset enable drops its request one cycle after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick; advances every counter |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| recovery_rst_req | output | 1 | Reset request from channel 0 |
| system_rst_req | output | 1 | Reset request from channels 1 and 2 |
| bark_irq | output | 1 | Bark interrupt from channel 0 |

## Verification
The bench builds the block with DATA_W = 8, keeping ADDR_W = 6 and three channels. The 8-bit width puts counter wrap-around within a few ticks. It also lets every counter value be swept against bite and bark thresholds at 0, the midpoint and the top. The full 64-entry address space is written and read back, which covers every unmapped and unaligned hole. Timing corners are checked at exact cycles: the status clear racing a live bark condition, and a request held for one cycle after its enable is cleared.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Control word bit positions (software-visible)
    localparam int CTL_IRQ_EN = 0;
    localparam int CTL_STATUS = 1;
    localparam int CTL_RST_EN = 2;

    // Register field selected by address bits [3:2]
    typedef enum logic [1:0] {
        FLD_COUNT = 2'd0,
        FLD_BITE  = 2'd1,
        FLD_BARK  = 2'd2,
        FLD_CTRL  = 2'd3
    } wd_field_e;

    // Per-channel reset machine
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_BITE  = 2'd2
    } ch_state_e;

    // Bark status machine (channel 0)
    typedef enum logic {
        BK_QUIET   = 1'b0,
        BK_LATCHED = 1'b1
    } bark_state_e;

endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int NUM_CH  = 3,
    parameter int BARK_CH = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic              hit,
    output logic [ADDR_W-5:0] ch_idx,
    output wd_field_e         fld,
    output logic [NUM_CH-1:0] wr_cnt,
    output logic [NUM_CH-1:0] wr_bite,
    output logic [NUM_CH-1:0] wr_bark,
    output logic [NUM_CH-1:0] wr_ctrl
);
    localparam int CH_BITS = ADDR_W - 4;

    logic aligned;
    logic ch_valid;
    logic fld_valid;

    assign ch_idx  = addr[ADDR_W-1:4];
    assign fld     = wd_field_e'(addr[3:2]);
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        ch_valid  = (int'(ch_idx) < NUM_CH);
        fld_valid = (fld != FLD_BARK) || (int'(ch_idx) == BARK_CH);
        hit       = aligned && ch_valid && fld_valid;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
        logic sel;
        assign sel        = wr_en && hit && (ch_idx == CH_BITS'(i));
        assign wr_cnt[i]  = sel && (fld == FLD_COUNT);
        assign wr_bite[i] = sel && (fld == FLD_BITE);
        assign wr_bark[i] = sel && (fld == FLD_BARK);
        assign wr_ctrl[i] = sel && (fld == FLD_CTRL);
    end

endmodule

// File: rtl/wdog_chan.sv
module wdog_chan
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit HAS_BARK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_cnt,
    input  logic              wr_bite,
    input  logic              wr_bark,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] bite_o,
    output logic [DATA_W-1:0] bark_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              req_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] bite_q;
    logic              rst_en_q;
    logic              reached;
    ch_state_e         state_q;
    ch_state_e         state_d;
    logic              status;
    logic              irq_en;

    // Counter: software load wins over the reference tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bite_q   <= '0;
            rst_en_q <= 1'b0;
        end else begin
            if (wr_bite) bite_q   <= wdata;
            if (wr_ctrl) rst_en_q <= wdata[CTL_RST_EN];
        end
    end

    assign reached = (cnt_q >= bite_q);

    // Reset machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (rst_en_q && reached)  state_d = CH_BITE;   // fire-on-arm
                else if (rst_en_q)        state_d = CH_ARMED;  // arm
            end
            CH_ARMED: begin
                if (!rst_en_q)            state_d = CH_OFF;    // disable
                else if (reached)         state_d = CH_BITE;   // reach
            end
            CH_BITE: begin
                if (!rst_en_q)            state_d = CH_OFF;    // disable
                else if (!reached)        state_d = CH_ARMED;  // service
            end
            default:                      state_d = CH_OFF;
        endcase
    end

    // Reset machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Reset machine: outputs
    always_comb begin
        req_o = (state_q == CH_BITE);
    end

    if (HAS_BARK) begin : g_bark
        logic [DATA_W-1:0] bark_q;
        logic              irq_en_q;
        logic              bark_cond;
        logic              ack;
        bark_state_e       bk_q;
        bark_state_e       bk_d;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bark_q   <= '0;
                irq_en_q <= 1'b0;
            end else begin
                if (wr_bark) bark_q   <= wdata;
                if (wr_ctrl) irq_en_q <= wdata[CTL_IRQ_EN];
            end
        end

        assign bark_cond = irq_en_q && (cnt_q >= bark_q);
        assign ack       = wr_ctrl && wdata[CTL_STATUS];

        // Bark machine: next-state logic
        always_comb begin
            bk_d = bk_q;
            unique case (bk_q)
                BK_QUIET:   if (bark_cond)         bk_d = BK_LATCHED; // latch
                BK_LATCHED: if (!bark_cond && ack) bk_d = BK_QUIET;   // acknowledge
            endcase
        end

        // Bark machine: state register
        always_ff @(posedge clk) begin
            if (!rst_n) bk_q <= BK_QUIET;
            else        bk_q <= bk_d;
        end

        // Bark machine: outputs
        always_comb begin
            status = (bk_q == BK_LATCHED);
            irq_en = irq_en_q;
            irq_o  = status && irq_en_q;
            bark_o = bark_q;
        end
    end else begin : g_no_bark
        logic unused_bark_wr;
        assign unused_bark_wr = wr_bark;
        assign status = 1'b0;
        assign irq_en = 1'b0;
        assign irq_o  = 1'b0;
        assign bark_o = '0;
    end

    always_comb begin
        ctrl_o             = '0;
        ctrl_o[CTL_IRQ_EN] = irq_en;
        ctrl_o[CTL_STATUS] = status;
        ctrl_o[CTL_RST_EN] = rst_en_q;
    end

    assign cnt_o  = cnt_q;
    assign bite_o = bite_q;

endmodule

// File: rtl/tri_wdog.sv
module tri_wdog
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              recovery_rst_req,
    output logic              system_rst_req,
    output logic              bark_irq
);
    localparam int CH_BITS  = ADDR_W - 4;
    localparam int RECOV_CH = 0;

    logic              hit;
    logic [CH_BITS-1:0] ch_idx;
    wd_field_e         fld;
    logic [NUM_CH-1:0] ch_wr_cnt;
    logic [NUM_CH-1:0] ch_wr_bite;
    logic [NUM_CH-1:0] ch_wr_bark;
    logic [NUM_CH-1:0] ch_wr_ctrl;
    logic [DATA_W-1:0] ch_cnt  [NUM_CH];
    logic [DATA_W-1:0] ch_bite [NUM_CH];
    logic [DATA_W-1:0] ch_bark [NUM_CH];
    logic [DATA_W-1:0] ch_ctrl [NUM_CH];
    logic [NUM_CH-1:0] ch_req;
    logic [NUM_CH-1:0] ch_irq;
    logic [NUM_CH-1:0] ch_en;

    wdog_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .BARK_CH(RECOV_CH)
    ) decode_i (
        .addr   (bus_addr),
        .wr_en  (bus_wr),
        .hit    (hit),
        .ch_idx (ch_idx),
        .fld    (fld),
        .wr_cnt (ch_wr_cnt),
        .wr_bite(ch_wr_bite),
        .wr_bark(ch_wr_bark),
        .wr_ctrl(ch_wr_ctrl)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        wdog_chan #(
            .DATA_W  (DATA_W),
            .HAS_BARK(i == RECOV_CH)
        ) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (ref_tick),
            .wr_cnt (ch_wr_cnt[i]),
            .wr_bite(ch_wr_bite[i]),
            .wr_bark(ch_wr_bark[i]),
            .wr_ctrl(ch_wr_ctrl[i]),
            .wdata  (bus_wdata),
            .cnt_o  (ch_cnt[i]),
            .bite_o (ch_bite[i]),
            .bark_o (ch_bark[i]),
            .ctrl_o (ch_ctrl[i]),
            .req_o  (ch_req[i]),
            .irq_o  (ch_irq[i])
        );
        assign ch_en[i] = ch_ctrl[i][CTL_RST_EN];
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == CH_BITS'(i)) begin
                    case (fld)
                        FLD_COUNT: bus_rdata = ch_cnt[i];
                        FLD_BITE:  bus_rdata = ch_bite[i];
                        FLD_BARK:  bus_rdata = ch_bark[i];
                        FLD_CTRL:  bus_rdata = ch_ctrl[i];
                        default:   bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign recovery_rst_req = ch_req[RECOV_CH];
    assign system_rst_req   = |ch_req[NUM_CH-1:1];
    assign bark_irq         = |ch_irq;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_cnt0,
    input logic [DATA_W-1:0] cnt0,
    input logic [DATA_W-1:0] bite0,
    input logic [DATA_W-1:0] bark0,
    input logic [DATA_W-1:0] ctrl0,
    input logic [NUM_CH-1:0] en_vec,
    input logic              rec_req,
    input logic              sys_req,
    input logic              irq
);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt0) |=> (cnt0 == $past(cnt0) + 1'b1));

    // R3
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt0 |=> (cnt0 == $past(wdata)));

    // R6
    recovery_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rec_req == $past(ctrl0[CTL_RST_EN] && (cnt0 >= bite0))));

    // R7
    system_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_vec[NUM_CH-1:1]) == '0) |-> !sys_req);

    // R8
    bark_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0[CTL_IRQ_EN] && (cnt0 >= bark0)) |=> ctrl0[CTL_STATUS]);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl0[CTL_STATUS] |-> !irq);

    // R11
    disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_vec[0] |=> !rec_req);

endmodule

bind tri_wdog wdog_chk #(
    .DATA_W(DATA_W),
    .NUM_CH(NUM_CH)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (ref_tick),
    .wdata  (bus_wdata),
    .wr_cnt0(ch_wr_cnt[0]),
    .cnt0   (ch_cnt[0]),
    .bite0  (ch_bite[0]),
    .bark0  (ch_bark[0]),
    .ctrl0  (ch_ctrl[0]),
    .en_vec (ch_en),
    .rec_req(recovery_rst_req),
    .sys_req(system_rst_req),
    .irq    (bark_irq)
);

// File: tb/tri_wdog_tb_top.sv
module tri_wdog_tb_top;
    localparam int DW  = 8;
    localparam int AW  = 6;
    localparam int NCH = 3;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick  = 1'b0;
    logic          wr    = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rec;
    logic          sys;
    logic          irq;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    always #5 clk = ~clk;

    tri_wdog #(.DATA_W(DW), .ADDR_W(AW), .NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(tick), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .recovery_rst_req(rec), .system_rst_req(sys), .bark_irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 120000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(int a, int d);
        @(negedge clk);
        addr  = AW'(a);
        wdata = DW'(d);
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic bus_read(int a, output int d);
        addr = AW'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int pat(int a);
        return (a * 37 + 11) % 256;
    endfunction

    function automatic int map_exp(int a);
        int ch  = a >> 4;
        int fld = (a >> 2) & 3;
        if ((a & 3) != 0 || ch >= NCH) return 0;
        if (fld == 2 && ch != 0) return 0;
        if (fld == 3) return (ch == 0) ? (pat(a) & 5) : (pat(a) & 4);
        return pat(a);
    endfunction

    function automatic int bite_val(int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 127;
            3: return 128;
            4: return 254;
            default: return 255;
        endcase
    endfunction

    task automatic clear_all();
        for (int ch = 0; ch < NCH; ch++) begin
            bus_write(ch * 16 + 12, 0);
            bus_write(ch * 16 + 12, 2);
            bus_write(ch * 16 + 0, 0);
            bus_write(ch * 16 + 4, 0);
        end
        bus_write(8, 0);
        bus_write(12, 2);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything zero after reset
        for (int a = 0; a < 64; a++) begin
            bus_read(a, v);
            check($sformatf("R1 reg %0h", a), v, 0);
        end
        check("R1 recovery", int'(rec), 0);
        check("R1 system", int'(sys), 0);
        check("R1 irq", int'(irq), 0);

        // R4 / R5: full address sweep write then read back
        for (int a = 0; a < 64; a++) bus_write(a, pat(a));
        for (int a = 0; a < 64; a++) begin
            bus_read(a, v);
            check($sformatf("R4 R5 map %0h", a), v, map_exp(a));
        end
        settle();
        check("R7 map recovery", int'(rec),
              int'(((pat(12) >> 2) & 1) == 1 && pat(0) >= pat(4)));
        check("R7 map system", int'(sys),
              int'((((pat(28) >> 2) & 1) == 1 && pat(16) >= pat(20)) ||
                   (((pat(44) >> 2) & 1) == 1 && pat(32) >= pat(36))));
        check("R10 map irq", int'(irq), 0);

        // R2: ticking and wrap
        clear_all();
        bus_write(16, 252);
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            bus_read(16, v);
            check($sformatf("R2 tick %0d", n), v, (252 + n) % 256);
        end
        repeat (3) @(negedge clk);
        bus_read(16, v);
        check("R2 hold", v, 4);

        // R3: load wins over tick
        @(negedge clk);
        tick = 1'b1; addr = AW'(16); wdata = 8'h40; wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0;
        bus_read(16, v);
        check("R3 load priority", v, 64);

        // R6 / R7: bite compare sweep on each channel
        for (int ch = 0; ch < NCH; ch++) begin
            clear_all();
            for (int bi = 0; bi < 6; bi++) begin
                int b = bite_val(bi);
                bus_write(ch * 16 + 4, b);
                bus_write(ch * 16 + 12, 4);
                for (int c = 0; c < 256; c++) begin
                    int e = (c >= b) ? 1 : 0;
                    bus_write(ch * 16, c);
                    settle();
                    check($sformatf("R6 R7 ch%0d bite %0d cnt %0d rec", ch, b, c),
                          int'(rec), (ch == 0) ? e : 0);
                    check($sformatf("R6 R7 ch%0d bite %0d cnt %0d sys", ch, b, c),
                          int'(sys), (ch == 0) ? 0 : e);
                end
            end
        end

        // R11: disable drops request one cycle after the write
        clear_all();
        bus_write(20, 0);
        bus_write(16, 5);
        bus_write(28, 4);
        settle();
        check("R11 active", int'(sys), 1);
        bus_write(28, 0);
        check("R11 held one cycle", int'(sys), 1);
        settle();
        check("R11 dropped", int'(sys), 0);

        // R8 / R10: bark threshold sweep on channel 0
        clear_all();
        for (int bi = 0; bi < 3; bi++) begin
            int bk = (bi == 0) ? 0 : ((bi == 1) ? 128 : 255);
            bus_write(8, bk);
            for (int c = 0; c < 256; c++) begin
                int e = (c >= bk) ? 1 : 0;
                bus_write(12, 0);
                bus_write(12, 2);
                bus_write(0, c);
                bus_write(12, 1);
                settle();
                bus_read(12, v);
                check($sformatf("R8 bark %0d cnt %0d", bk, c), v, 1 | (e << 1));
                check($sformatf("R10 bark %0d cnt %0d irq", bk, c), int'(irq), e);
            end
        end

        // R9: clear loses to live condition, wins once it is gone
        clear_all();
        bus_write(8, 128);
        bus_write(0, 144);
        bus_write(12, 1);
        settle();
        bus_write(12, 3);
        bus_read(12, v);
        check("R9 set wins", v, 3);
        bus_write(0, 16);
        bus_write(12, 3);
        bus_read(12, v);
        check("R9 cleared", v, 1);
        check("R9 irq low", int'(irq), 0);

        // R10: latched status with enable off keeps the line low
        bus_write(0, 144);
        settle();
        check("R10 irq high", int'(irq), 1);
        bus_write(12, 0);
        bus_read(12, v);
        check("R10 status kept", v, 2);
        check("R10 masked", int'(irq), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule